// File: doc/BRIEF.md
# User Status Register with Sticky Exception Flags

This block holds one 32-bit user-visible status word. Software configures rounding, prefetch, packet-counting and loop fields through a single write port. The arithmetic units raise one-cycle event pulses, and each pulse latches a sticky flag. A flag stays set until software writes it back to zero. Reading the word returns the control fields, the sticky flags, the architected trap-enable field and a live prefetch-busy indicator.

Trap enables are held twice. The architected field reads back at once after a write. A separate set of effective enables is loaded from that field only when a synchronize pulse arrives, and only the effective enables arm the trap request. The trap request is registered. It rises one cycle after an event pulse that meets an armed enable. Saturation events set their flag but can never raise a trap.

Top module: `usr_status_reg`

## Requirements
- R1: While rst_n is low and right after release, every stored field is zero: sticky flags, trap-enable field, effective enables, rounding mode (00 = nearest-even), both prefetch fields, packet-count enables and loop value. trap_req is 0 and status_word equals {pf_busy, 31'b0}.
- R2: Event bit evt[k] sets sticky flag status_word[k] at the next clock edge. The bits are 0 = saturation, 1 = invalid, 2 = divide-by-zero, 3 = overflow, 4 = underflow, 5 = inexact. A flag only returns to 0 through a software write with that bit at 0.
- R3: When a write and an event hit the same flag in one cycle, the flag ends up set.
- R4: A write loads status_word[29:25] from wr_data[29:25], with the same invalid..inexact order as flags 1..5. The new value reads back from the next cycle onward.
- R5: The effective enables change only on a cycle with sync_pulse high. They then take the trap-enable field value held before that edge, so a write in the same cycle is not captured.
- R6: trap_req is high in the cycle after a clock edge where some evt[k], k in 1..5, was high and effective enable k-1 was set. Otherwise trap_req is low. evt[0] never causes a trap.
- R7: A write loads rounding mode bits 23:22 (on round_mode), data prefetch bits 14:13 (on dfetch_level), packet-count enables bits 12:10 and loop value bits 9:8.
- R8: Instruction prefetch bits 16:15 (on ifetch_lines) take 00, 01 or 10 from a write. A write carrying 11 there leaves the field at its prior value, and the rest of that write still applies.
- R9: status_word[31] follows pf_busy in the same cycle. Bits 30, 24, 21:17 and 7:6 always read 0, whatever is written.
- R10: With wr_en low, no control field and no trap-enable field bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| evt | input | 6 | One-cycle event pulses, bit order as in R2 |
| sync_pulse | input | 1 | Loads the effective trap enables |
| pf_busy | input | 1 | Prefetch-in-progress indicator |
| status_word | output | 32 | Current register value |
| round_mode | output | 2 | Decoded rounding mode |
| ifetch_lines | output | 2 | Instruction prefetch setting |
| dfetch_level | output | 2 | Data prefetch level |
| trap_req | output | 1 | Registered trap request |

## Verification
The assertions assume that evt, wr_en, wr_data and sync_pulse are stable around each rising edge. They also assume that an event pulse covers one edge for each event it reports, so a pulse held high counts again on every edge. The stimulus drives all inputs one time unit after a rising edge and holds them for the whole cycle. A pulse held across consecutive steps is modelled as repeated events, which matches what the properties take for granted. No input combination is excluded. Simultaneous write, event and sync are driven on purpose, because R3 and R5 define those cases.

// File: rtl/usr_pkg.sv
package usr_pkg;
  localparam int REG_W    = 32;
  localparam int EXC_N    = 5;
  localparam int FLAG_N   = EXC_N + 1;
  localparam int FLAG_LSB = 0;
  localparam int TEN_LSB  = 25;
  localparam int RND_LSB  = 22;
  localparam int IPF_LSB  = 15;
  localparam int DPF_LSB  = 13;
  localparam int PCE_LSB  = 10;
  localparam int LPC_LSB  = 8;
  localparam int BUSY_BIT = 31;
  localparam int RND_W    = 2;
  localparam int IPF_W    = 2;
  localparam int DPF_W    = 2;
  localparam int PCE_W    = 3;
  localparam int LPC_W    = 2;

  typedef enum logic [RND_W-1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_DOWN      = 2'b10,
    RND_UP        = 2'b11
  } round_e;

  localparam logic [IPF_W-1:0] IPF_RSVD = 2'b11;

  typedef struct packed {
    round_e             rnd;
    logic [IPF_W-1:0]   ipf;
    logic [DPF_W-1:0]   dpf;
    logic [PCE_W-1:0]   pce;
    logic [LPC_W-1:0]   lpc;
  } ctrl_t;
endpackage

// File: rtl/usr_sticky_bank.sv
module usr_sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_val_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_comb begin
      flags_d[k] = flags_q[k];
      if (wr_en_i) flags_d[k] = wr_val_i[k];
      if (evt_i[k]) flags_d[k] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[k] <= 1'b0;
      else         flags_q[k] <= flags_d[k];
    end
  end

  assign flags_o = flags_q;

  // R2: without a write no set flag drops
  a_r2_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R3: an event always leaves its flag set, write or not
  a_r3_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/usr_ctrl_fields.sv
module usr_ctrl_fields
  import usr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  ctrl_t wr_ctrl_i,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d.rnd = wr_ctrl_i.rnd;
      ctrl_d.dpf = wr_ctrl_i.dpf;
      ctrl_d.pce = wr_ctrl_i.pce;
      ctrl_d.lpc = wr_ctrl_i.lpc;
      if (wr_ctrl_i.ipf != IPF_RSVD) ctrl_d.ipf = wr_ctrl_i.ipf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.rnd <= RND_NEAR_EVEN;
      ctrl_q.ipf <= '0;
      ctrl_q.dpf <= '0;
      ctrl_q.pce <= '0;
      ctrl_q.lpc <= '0;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

  // R8: the reserved prefetch code is never held
  a_r8_ipf_not_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.ipf != IPF_RSVD);
  // R10: fields hold without a write
  a_r10_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q));
  // R7: rounding mode follows a write
  a_r7_round_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_q.rnd == $past(wr_ctrl_i.rnd)));
endmodule

// File: rtl/usr_trap_arm.sv
module usr_trap_arm #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_bits_i,
  input  logic         sync_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] en_field_o,
  output logic         trap_o
);
  logic [N-1:0] en_q, en_d;
  logic [N-1:0] eff_q, eff_d;
  logic         trap_q, trap_d;

  always_comb begin
    en_d   = wr_en_i ? wr_bits_i : en_q;
    eff_d  = sync_i ? en_q : eff_q;
    trap_d = |(evt_i & eff_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      eff_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      if (wr_en_i) en_q <= en_d;
      if (sync_i)  eff_q <= eff_d;
      trap_q <= trap_d;
    end
  end

  assign en_field_o = en_q;
  assign trap_o     = trap_q;

  // R4: field reads back the written value
  a_r4_field_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (en_q == $past(wr_bits_i)));
  // R5: effective enables move only on sync
  a_r5_eff_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(eff_q));
  // R5: sync captures the pre-edge field
  a_r5_sync_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (eff_q == $past(en_q)));
  // R6: trap only after an armed event
  a_r6_no_unarmed_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & eff_q) == '0) |=> !trap_q);
  // R6: an armed event always traps
  a_r6_armed_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & eff_q) != '0) |=> trap_q);
endmodule

// File: rtl/usr_status_reg.sv
module usr_status_reg
  import usr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [FLAG_N-1:0] evt,
  input  logic              sync_pulse,
  input  logic              pf_busy,
  output logic [REG_W-1:0]  status_word,
  output logic [RND_W-1:0]  round_mode,
  output logic [IPF_W-1:0]  ifetch_lines,
  output logic [DPF_W-1:0]  dfetch_level,
  output logic              trap_req
);
  ctrl_t             wr_ctrl;
  ctrl_t             ctrl;
  logic [FLAG_N-1:0] flags;
  logic [EXC_N-1:0]  en_field;
  logic              unused_wr_bits;

  always_comb begin
    wr_ctrl.rnd = round_e'(wr_data[RND_LSB +: RND_W]);
    wr_ctrl.ipf = wr_data[IPF_LSB +: IPF_W];
    wr_ctrl.dpf = wr_data[DPF_LSB +: DPF_W];
    wr_ctrl.pce = wr_data[PCE_LSB +: PCE_W];
    wr_ctrl.lpc = wr_data[LPC_LSB +: LPC_W];
  end

  assign unused_wr_bits = ^{wr_data[31:30], wr_data[24], wr_data[21:17], wr_data[7:6]};

  usr_sticky_bank #(.N(FLAG_N)) u_flags (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_val_i (wr_data[FLAG_LSB +: FLAG_N]),
    .evt_i    (evt),
    .flags_o  (flags)
  );

  usr_ctrl_fields u_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_ctrl_i (wr_ctrl),
    .ctrl_o    (ctrl)
  );

  usr_trap_arm #(.N(EXC_N)) u_trap (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_bits_i  (wr_data[TEN_LSB +: EXC_N]),
    .sync_i     (sync_pulse),
    .evt_i      (evt[FLAG_N-1:1]),
    .en_field_o (en_field),
    .trap_o     (trap_req)
  );

  always_comb begin
    status_word                       = '0;
    status_word[FLAG_LSB +: FLAG_N]   = flags;
    status_word[LPC_LSB +: LPC_W]     = ctrl.lpc;
    status_word[PCE_LSB +: PCE_W]     = ctrl.pce;
    status_word[DPF_LSB +: DPF_W]     = ctrl.dpf;
    status_word[IPF_LSB +: IPF_W]     = ctrl.ipf;
    status_word[RND_LSB +: RND_W]     = ctrl.rnd;
    status_word[TEN_LSB +: EXC_N]     = en_field;
    status_word[BUSY_BIT]             = pf_busy;
  end

  assign round_mode   = ctrl.rnd;
  assign ifetch_lines = ctrl.ipf;
  assign dfetch_level = ctrl.dpf;

  // R2: saturation flag is visible in bit 0 one cycle after its pulse
  a_r2_sat_visible: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> status_word[0]);
endmodule

// File: tb/usr_status_reg_bench.sv
module usr_status_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [5:0]  evt;
  logic        sync_pulse;
  logic        pf_busy;
  logic [31:0] status_word;
  logic [1:0]  round_mode, ifetch_lines, dfetch_level;
  logic        trap_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [5:0] m_flags;
  logic [4:0] m_en, m_eff;
  logic       m_trap;
  logic [1:0] m_rnd, m_ipf, m_dpf, m_lpc;
  logic [2:0] m_pce;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  usr_status_reg u_usr_status_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .evt(evt),
    .sync_pulse(sync_pulse), .pf_busy(pf_busy), .status_word(status_word),
    .round_mode(round_mode), .ifetch_lines(ifetch_lines),
    .dfetch_level(dfetch_level), .trap_req(trap_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic busy);
    return {busy, 1'b0, m_en, 1'b0, m_rnd, 5'b0, m_ipf, m_dpf, m_pce, m_lpc, 2'b0, m_flags};
  endfunction

  task automatic compare_all(input string tag);
    check({tag, " status_word"}, status_word, exp_word(pf_busy));
    check({tag, " trap_req"}, {31'b0, trap_req}, {31'b0, m_trap});
    check({tag, " round_mode"}, {30'b0, round_mode}, {30'b0, m_rnd});
    check({tag, " ifetch_lines"}, {30'b0, ifetch_lines}, {30'b0, m_ipf});
    check({tag, " dfetch_level"}, {30'b0, dfetch_level}, {30'b0, m_dpf});
  endtask

  task automatic step(input string tag, input logic w, input logic [31:0] d,
                      input logic [5:0] e, input logic s, input logic b);
    wr_en = w; wr_data = d; evt = e; sync_pulse = s; pf_busy = b;
    @(posedge clk); #1;
    m_trap  = |(e[5:1] & m_eff);
    if (s) m_eff = m_en;
    m_flags = (w ? d[5:0] : m_flags) | e;
    if (w) begin
      m_en  = d[29:25];
      m_rnd = d[23:22];
      m_dpf = d[14:13];
      m_pce = d[12:10];
      m_lpc = d[9:8];
      if (d[16:15] != 2'b11) m_ipf = d[16:15];
    end
    compare_all(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '1; evt = '1; sync_pulse = 1'b1; pf_busy = 1'b0;
    m_flags = '0; m_en = '0; m_eff = '0; m_trap = 1'b0;
    m_rnd = '0; m_ipf = '0; m_dpf = '0; m_pce = '0; m_lpc = '0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 in reset");
    evt = '0; sync_pulse = 1'b0; wr_data = '0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    compare_all("R1 after release");
    pf_busy = 1'b1; #1;
    check("R1 R9 busy mirror", status_word, 32'h8000_0000);

    // R2: every event pattern, then hold
    for (int e = 0; e < 64; e++) begin
      step("R2 clear", 1'b1, 32'h0, 6'h0, 1'b0, 1'b0);
      step("R2 set", 1'b0, 32'h0, 6'(e), 1'b0, 1'b0);
      step("R2 hold", 1'b0, 32'h0, 6'h0, 1'b0, 1'b1);
    end

    // R3: write and event together
    step("R3 zero write with events", 1'b1, 32'h0, 6'h3F, 1'b0, 1'b0);
    check("R3 all flags set", {26'b0, status_word[5:0]}, 32'h3F);
    step("R3 clear", 1'b1, 32'h0, 6'h0, 1'b0, 1'b0);
    step("R3 split", 1'b1, 32'h15, 6'h2A, 1'b0, 1'b0);
    check("R3 merged", {26'b0, status_word[5:0]}, 32'h3F);

    // R4 R5 R6: every enable pattern against every event pattern
    for (int en = 0; en < 32; en++) begin
      step("R4 write enables", 1'b1, 32'(en) << 25, 6'h0, 1'b0, 1'b0);
      step("R5 event before sync", 1'b0, 32'h0, 6'h3E, 1'b0, 1'b0);
      step("R5 write during sync", 1'b1, (32'(en) << 25), 6'h0, 1'b1, 1'b0);
      for (int e = 0; e < 64; e++)
        step("R6 trap", 1'b0, 32'h0, 6'(e), 1'b0, 1'b0);
    end
    step("R5 sync same-cycle write", 1'b1, 32'h3E00_0000, 6'h0, 1'b1, 1'b0);
    step("R5 old enables used", 1'b1, 32'h0, 6'h02, 1'b1, 1'b0);

    // R7 R8 R9: all control codes, reserved bits forced high
    for (int i = 0; i < 2048; i++) begin
      logic [31:0] d;
      d = 32'h413E_00C0;
      d[23:22] = 2'(i);
      d[16:15] = 2'(i >> 2);
      d[14:13] = 2'(i >> 4);
      d[12:10] = 3'(i >> 6);
      d[9:8]   = 2'(i >> 9);
      step("R7 R8 R9 field sweep", 1'b1, d, 6'h0, 1'b0, 1'(i));
    end

    // R8 directed
    step("R8 set one line", 1'b1, 32'h0000_8000, 6'h0, 1'b0, 1'b0);
    step("R8 reserved ignored", 1'b1, 32'h0081_8000, 6'h0, 1'b0, 1'b0);
    check("R8 ifetch kept", {30'b0, ifetch_lines}, 32'h1);
    check("R8 round applied", {30'b0, round_mode}, 32'h2);

    // R10: wr_en low with busy data
    for (int i = 0; i < 64; i++) begin
      lfsr = next_rand(lfsr);
      step("R10 hold", 1'b0, lfsr, 6'h0, 1'b0, 1'b0);
    end

    // mixed sweep
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1, r2;
      lfsr = next_rand(lfsr); r1 = lfsr;
      lfsr = next_rand(lfsr); r2 = lfsr;
      step("R2 R5 R6 R10 mixed", r2[1:0] == 2'b00, r1,
           r2[8:3] & r2[14:9], r2[17:15] == 3'b000, r2[20]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule